// File: doc/BRIEF.md
# Predicated Integer Execution Unit

This block is a single-issue execution core. Every operation is guarded, so a program can turn if/else chains into straight-line code with no branches. The core holds two register files. One holds thirty-two 32-bit integer registers. The other holds thirty-two one-bit condition flags.

Each clock cycle the core accepts at most one decoded operation. An operation has:
- an opcode,
- two source indices,
- an immediate-select bit and a 16-bit immediate,
- a destination index,
- a guard index naming a condition flag.

Compare operations write a condition flag. Flag-logic operations combine condition flags. Add-immediate writes an integer register. If the guard flag is false, the operation changes nothing.

The result is written on the clock edge that ends the cycle in which the operation is presented. The next operation therefore sees the new value with no stall. Two asynchronous read ports expose both register files, so the surrounding logic can observe state.

Top module: `pred_exec_top`

## Requirements
- R1: A synchronous reset sets every integer register to 0. It also clears every condition flag, except flag 0, which reads 1.
- R2: Opcode 1 (add-immediate) writes integer register `dst`. The value written is integer register `srcA` plus the 16-bit immediate, sign-extended to 32 bits. The sum wraps modulo 2^32.
- R3: Opcode 2 sets flag `dst` to 1 exactly when its operands are equal. Opcode 3 sets it to 1 exactly when they differ.
- R4: Opcode 4 sets flag `dst` when operand A is greater than or equal to operand B. Opcode 5 sets it when A is strictly less than B. Both compares are signed 32-bit. For all four compares (opcodes 2 to 5), operand A is integer register `srcA`. Operand B is integer register `srcB` when `useImm` is 0, and the sign-extended immediate when `useImm` is 1.
- R5: Opcode 6 writes the AND of flags `srcA` and `srcB` to flag `dst`. Opcode 7 writes their OR. Opcode 8 writes the inverse of flag `srcA`.
- R6: When flag `guard` is 0, the operation leaves both register files unchanged.
- R7: Flag 0 always reads 1, and any write to it is discarded. A guard index of 0 therefore always executes.
- R8: When `opValid` is low, or the opcode is 0 or in the range 9 to 15, both register files are left unchanged, whatever the guard.
- R9: A result written by one operation is seen by the operation issued in the next cycle. It is also visible on the read ports once the write edge has passed.
- R10: The core correctly runs the following branch-free sequence of compares, flag logic and two guarded adds. A register below 30 gets 2000 added. A register from 30 to 1899 gets 1900 added. A register at 1900 or above is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code |
| srcA | input | 5 | First source index (integer or flag) |
| srcB | input | 5 | Second source index (integer or flag) |
| useImm | input | 1 | Compare operand B comes from the immediate |
| imm | input | 16 | Signed immediate |
| dst | input | 5 | Destination index |
| guard | input | 5 | Guarding flag index |
| intRdAddr | input | 5 | Integer read port address |
| intRdData | output | 32 | Integer read port data |
| predRdAddr | input | 5 | Flag read port address |
| predRdData | output | 1 | Flag read port data |

## Verification
A wrong internal state appears at the read ports in the first sample after the write edge. It also spoils every later operation that uses that register or flag as a source or guard. If a guard decodes wrongly, a squashed operation changes a register that was set up just beforehand, or an operation that should run fails to. This is visible in the very next read.

The compare sweeps are exhaustive over a small set of signed values, against both a register and the immediate. The date-adjust sequence chains compares, flag logic and guarded adds, so a fault at any stage shows in its final sum.

// File: rtl/pred_exec_pkg.sv
`timescale 1ns/1ps
package pred_exec_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'd0,
    OP_ADDI = 4'd1,
    OP_CEQ  = 4'd2,
    OP_CNE  = 4'd3,
    OP_CGE  = 4'd4,
    OP_CLT  = 4'd5,
    OP_PAND = 4'd6,
    OP_POR  = 4'd7,
    OP_PNOT = 4'd8
  } opKind_e;

  typedef enum logic [2:0] {
    RES_EQ,
    RES_NE,
    RES_GE,
    RES_LT,
    RES_AND,
    RES_OR,
    RES_NOT
  } predSel_e;

  typedef struct packed {
    logic     intWe;
    logic     predWe;
    logic     useImm;
    predSel_e predSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/pred_exec_ctrl.sv
`timescale 1ns/1ps
module pred_exec_ctrl
  import pred_exec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  input  logic             useImm,
  input  logic             guardVal,
  output ctrlStrobe_t      str
);

  logic opLive;
  assign opLive = opValid && guardVal;

  always_comb begin
    str        = '0;
    str.useImm = useImm;
    str.predSel = RES_EQ;
    case (opCode)
      OP_ADDI: str.intWe = opLive;
      OP_CEQ: begin
        str.predWe  = opLive;
        str.predSel = RES_EQ;
      end
      OP_CNE: begin
        str.predWe  = opLive;
        str.predSel = RES_NE;
      end
      OP_CGE: begin
        str.predWe  = opLive;
        str.predSel = RES_GE;
      end
      OP_CLT: begin
        str.predWe  = opLive;
        str.predSel = RES_LT;
      end
      OP_PAND: begin
        str.predWe  = opLive;
        str.predSel = RES_AND;
      end
      OP_POR: begin
        str.predWe  = opLive;
        str.predSel = RES_OR;
      end
      OP_PNOT: begin
        str.predWe  = opLive;
        str.predSel = RES_NOT;
      end
      default: begin
        str.intWe  = 1'b0;
        str.predWe = 1'b0;
      end
    endcase
  end

  // R6: a false guard yields no write strobe
  p_guard_squash_r6: assert property (@(posedge clk) disable iff (rst)
    !guardVal |-> (!str.intWe && !str.predWe));

  // R8: undefined opcodes never write
  p_undef_nop_r8: assert property (@(posedge clk) disable iff (rst)
    (opCode == 4'd0 || opCode > 4'd8) |-> (!str.intWe && !str.predWe));

  // R8: an idle cycle never writes
  p_idle_nop_r8: assert property (@(posedge clk) disable iff (rst)
    !opValid |-> (!str.intWe && !str.predWe));

  // R2: at most one file written per operation
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({str.intWe, str.predWe}));

endmodule

// File: rtl/pred_exec_dpath.sv
`timescale 1ns/1ps
module pred_exec_dpath
  import pred_exec_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       str,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  dst,
  input  logic [IDX_W-1:0]  guard,
  output logic              guardVal,
  input  logic [IDX_W-1:0]  intRdAddr,
  output logic [DATA_W-1:0] intRdData,
  input  logic [IDX_W-1:0]  predRdAddr,
  output logic              predRdData
);

  logic [NUM_REGS-1:0][DATA_W-1:0] intFile;
  logic [NUM_REGS-1:1]             predStore;
  logic [NUM_REGS-1:0]             predFile;

  logic [DATA_W-1:0] immExt, opA, opB, sum;
  logic              pA, pB, predResult;

  // flag 0 is hard-wired true
  assign predFile = {predStore, 1'b1};

  assign immExt = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign opA    = intFile[srcA];
  assign opB    = str.useImm ? immExt : intFile[srcB];
  assign sum    = opA + immExt;
  assign pA     = predFile[srcA];
  assign pB     = predFile[srcB];

  always_comb begin
    case (str.predSel)
      RES_EQ:  predResult = (opA == opB);
      RES_NE:  predResult = (opA != opB);
      RES_GE:  predResult = ($signed(opA) >= $signed(opB));
      RES_LT:  predResult = ($signed(opA) <  $signed(opB));
      RES_AND: predResult = pA & pB;
      RES_OR:  predResult = pA | pB;
      RES_NOT: predResult = ~pA;
      default: predResult = 1'b0;
    endcase
  end

  assign guardVal   = predFile[guard];
  assign intRdData  = intFile[intRdAddr];
  assign predRdData = predFile[predRdAddr];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_int
      always_ff @(posedge clk) begin
        if (rst)
          intFile[i] <= '0;
        else if (str.intWe && dst == IDX_W'(i))
          intFile[i] <= sum;
      end
    end
    for (genvar j = 1; j < NUM_REGS; j++) begin : g_pred
      always_ff @(posedge clk) begin
        if (rst)
          predStore[j] <= 1'b0;
        else if (str.predWe && dst == IDX_W'(j))
          predStore[j] <= predResult;
      end
    end
  endgenerate

  // R7: flag 0 always reads true
  p_p0_true_r7: assert property (@(posedge clk) disable iff (rst)
    (predRdAddr == '0) |-> predRdData);

  // R7: a write aimed at flag 0 changes no stored flag
  p_p0_write_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (str.predWe && dst == '0) |=> $stable(predStore));

  // R6: without a flag write strobe the flag file holds
  p_pred_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !str.predWe |=> $stable(predStore));

  // R6: without an integer write strobe the integer file holds
  p_int_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !str.intWe |=> $stable(intFile));

endmodule

// File: rtl/pred_exec_top.sv
`timescale 1ns/1ps
module pred_exec_top
  import pred_exec_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [IDX_W-1:0]  srcA,
  input  logic [IDX_W-1:0]  srcB,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  dst,
  input  logic [IDX_W-1:0]  guard,
  input  logic [IDX_W-1:0]  intRdAddr,
  output logic [DATA_W-1:0] intRdData,
  input  logic [IDX_W-1:0]  predRdAddr,
  output logic              predRdData
);

  ctrlStrobe_t str;
  logic        guardVal;

  pred_exec_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opValid  (opValid),
    .opCode   (opCode),
    .useImm   (useImm),
    .guardVal (guardVal),
    .str      (str)
  );

  pred_exec_dpath #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IMM_W    (IMM_W)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .str        (str),
    .srcA       (srcA),
    .srcB       (srcB),
    .imm        (imm),
    .dst        (dst),
    .guard      (guard),
    .guardVal   (guardVal),
    .intRdAddr  (intRdAddr),
    .intRdData  (intRdData),
    .predRdAddr (predRdAddr),
    .predRdData (predRdData)
  );

endmodule

// File: tb/pred_exec_top_bench.sv
`timescale 1ns/1ps
module pred_exec_top_bench;
  import pred_exec_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [4:0]  srcA = '0, srcB = '0, dst = '0, guard = '0;
  logic        useImm = 1'b0;
  logic [15:0] imm = '0;
  logic [4:0]  intRdAddr = '0, predRdAddr = '0;
  logic [31:0] intRdData;
  logic        predRdData;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pred_exec_top u_pred_exec_top (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .useImm(useImm), .imm(imm), .dst(dst),
    .guard(guard), .intRdAddr(intRdAddr), .intRdData(intRdData),
    .predRdAddr(predRdAddr), .predRdData(predRdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [4:0] a, input logic [4:0] b,
                       input logic ui, input logic [15:0] im, input logic [4:0] d,
                       input logic [4:0] g, input logic v = 1'b1);
    @(negedge clk);
    opValid = v; opCode = op; srcA = a; srcB = b; useImm = ui; imm = im; dst = d; guard = g;
    @(posedge clk);
    #1 opValid = 1'b0;
  endtask

  task automatic rdInt(input logic [4:0] idx, output logic [31:0] val);
    intRdAddr = idx; #1 val = intRdData;
  endtask

  task automatic rdPred(input logic [4:0] idx, output logic val);
    predRdAddr = idx; #1 val = predRdData;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic pv;
    logic signed [31:0] vals [6] = '{-3, -1, 0, 1, 2, 1900};
    logic signed [31:0] years [9] = '{0, 29, 30, 31, 1899, 1900, 1901, -5, 5000};

    doReset();
    // R1: reset state of both files
    for (int i = 0; i < 32; i++) begin
      rdInt(5'(i), rv); chk("R1 int reset", rv, 32'd0);
      rdPred(5'(i), pv); chk("R1 flag reset", {31'd0, pv}, (i == 0) ? 32'd1 : 32'd0);
    end

    // R2: add-immediate with sign extension
    foreach (vals[k]) begin
      issue(OP_ADDI, 5'd0, 5'd0, 1'b0, vals[k][15:0], 5'd20, 5'd0);
      rdInt(5'd20, rv); chk("R2 addi", rv, vals[k]);
    end
    issue(OP_ADDI, 5'd0, 5'd0, 1'b0, 16'h8000, 5'd21, 5'd0);
    rdInt(5'd21, rv); chk("R2 addi min imm", rv, 32'hFFFF8000);
    issue(OP_ADDI, 5'd0, 5'd0, 1'b0, 16'h7FFF, 5'd21, 5'd0);
    rdInt(5'd21, rv); chk("R2 addi max imm", rv, 32'h00007FFF);
    // R9: back-to-back dependency
    issue(OP_ADDI, 5'd21, 5'd0, 1'b0, 16'd1, 5'd22, 5'd0);
    issue(OP_ADDI, 5'd22, 5'd0, 1'b0, 16'hFFFE, 5'd22, 5'd0);
    rdInt(5'd22, rv); chk("R9 chained addi", rv, 32'h00007FFE);
    // R2: every destination decodes separately
    for (int i = 1; i < 32; i++) issue(OP_ADDI, 5'd0, 5'd0, 1'b0, 16'(i * 3), 5'(i), 5'd0);
    for (int i = 1; i < 32; i++) begin
      rdInt(5'(i), rv); chk("R2 dst decode", rv, 32'(i * 3));
    end

    // set r1..r6 to the sweep values
    foreach (vals[k]) issue(OP_ADDI, 5'd0, 5'd0, 1'b0, vals[k][15:0], 5'(k + 1), 5'd0);
    // R3 R4: compare sweep, register and immediate operand B
    for (int ui = 0; ui < 2; ui++)
      foreach (vals[a])
        foreach (vals[b])
          for (int op = 2; op <= 5; op++) begin
            logic e;
            case (op)
              2: e = (vals[a] == vals[b]);
              3: e = (vals[a] != vals[b]);
              4: e = (vals[a] >= vals[b]);
              default: e = (vals[a] < vals[b]);
            endcase
            issue(4'(op), 5'(a + 1), 5'(b + 1), 1'(ui), vals[b][15:0], 5'd7, 5'd0);
            rdPred(5'd7, pv);
            chk((op < 4) ? "R3 eq/ne compare" : "R4 ge/lt compare", {31'd0, pv}, {31'd0, e});
          end

    // R5: flag logic over all input pairs
    for (int x = 0; x < 2; x++)
      for (int y = 0; y < 2; y++) begin
        issue(x ? OP_CEQ : OP_CNE, 5'd0, 5'd0, 1'b0, 16'd0, 5'd1, 5'd0);
        issue(y ? OP_CEQ : OP_CNE, 5'd0, 5'd0, 1'b0, 16'd0, 5'd2, 5'd0);
        issue(OP_PAND, 5'd1, 5'd2, 1'b0, 16'd0, 5'd3, 5'd0);
        issue(OP_POR,  5'd1, 5'd2, 1'b0, 16'd0, 5'd4, 5'd0);
        issue(OP_PNOT, 5'd1, 5'd0, 1'b0, 16'd0, 5'd5, 5'd0);
        rdPred(5'd3, pv); chk("R5 and", {31'd0, pv}, 32'(x & y));
        rdPred(5'd4, pv); chk("R5 or",  {31'd0, pv}, 32'(x | y));
        rdPred(5'd5, pv); chk("R5 not", {31'd0, pv}, 32'(!x));
      end

    // R6: false guard squashes every kind of write
    issue(OP_CNE, 5'd0, 5'd0, 1'b0, 16'd0, 5'd8, 5'd0);   // p8 = 0
    issue(OP_CEQ, 5'd0, 5'd0, 1'b0, 16'd0, 5'd9, 5'd0);   // p9 = 1
    issue(OP_ADDI, 5'd0, 5'd0, 1'b0, 16'd77, 5'd10, 5'd8);
    rdInt(5'd10, rv); chk("R6 squashed addi", rv, 32'd30);
    issue(OP_CNE, 5'd0, 5'd0, 1'b0, 16'd0, 5'd9, 5'd8);
    rdPred(5'd9, pv); chk("R6 squashed compare", {31'd0, pv}, 32'd1);
    issue(OP_PNOT, 5'd9, 5'd0, 1'b0, 16'd0, 5'd9, 5'd8);
    rdPred(5'd9, pv); chk("R6 squashed flag logic", {31'd0, pv}, 32'd1);
    issue(OP_ADDI, 5'd0, 5'd0, 1'b0, 16'd77, 5'd10, 5'd9);
    rdInt(5'd10, rv); chk("R6 true guard runs", rv, 32'd77);

    // R7: flag 0 ignores writes
    issue(OP_CNE, 5'd0, 5'd0, 1'b0, 16'd0, 5'd0, 5'd0);
    issue(OP_PNOT, 5'd0, 5'd0, 1'b0, 16'd0, 5'd0, 5'd0);
    rdPred(5'd0, pv); chk("R7 p0 stays true", {31'd0, pv}, 32'd1);
    issue(OP_ADDI, 5'd10, 5'd0, 1'b0, 16'd1, 5'd10, 5'd0);
    rdInt(5'd10, rv); chk("R7 p0 guard runs", rv, 32'd78);

    // R8: undefined opcodes and idle cycles are no-ops
    for (int op = 0; op < 16; op++) begin
      if (op >= 1 && op <= 8) continue;
      issue(4'(op), 5'd0, 5'd0, 1'b0, 16'd5, 5'd10, 5'd0);
      issue(4'(op), 5'd0, 5'd0, 1'b0, 16'd5, 5'd9, 5'd0);
      rdInt(5'd10, rv); chk("R8 undefined op int", rv, 32'd78);
      rdPred(5'd9, pv); chk("R8 undefined op flag", {31'd0, pv}, 32'd1);
    end
    issue(OP_ADDI, 5'd0, 5'd0, 1'b0, 16'd5, 5'd10, 5'd0, 1'b0);
    issue(OP_CNE, 5'd0, 5'd0, 1'b0, 16'd0, 5'd9, 5'd0, 1'b0);
    rdInt(5'd10, rv); chk("R8 idle int", rv, 32'd78);
    rdPred(5'd9, pv); chk("R8 idle flag", {31'd0, pv}, 32'd1);

    // R1: reset in mid-run
    doReset();
    rdInt(5'd10, rv); chk("R1 reset again int", rv, 32'd0);
    rdPred(5'd9, pv); chk("R1 reset again flag", {31'd0, pv}, 32'd0);
    rdPred(5'd0, pv); chk("R1 reset again p0", {31'd0, pv}, 32'd1);

    // R10: branch-free date adjust
    foreach (years[k]) begin
      logic signed [31:0] e;
      e = (years[k] < 30) ? years[k] + 2000 : (years[k] < 1900) ? years[k] + 1900 : years[k];
      issue(OP_ADDI, 5'd0, 5'd0, 1'b0, years[k][15:0], 5'd1, 5'd0);
      issue(OP_CLT,  5'd1, 5'd0, 1'b1, 16'd1900, 5'd1, 5'd0);
      issue(OP_CLT,  5'd1, 5'd0, 1'b1, 16'd30,   5'd2, 5'd0);
      issue(OP_PNOT, 5'd2, 5'd0, 1'b0, 16'd0,    5'd3, 5'd0);
      issue(OP_PAND, 5'd1, 5'd2, 1'b0, 16'd0,    5'd4, 5'd0);
      issue(OP_PAND, 5'd1, 5'd3, 1'b0, 16'd0,    5'd5, 5'd0);
      issue(OP_ADDI, 5'd1, 5'd0, 1'b0, 16'd1900, 5'd1, 5'd5);
      issue(OP_ADDI, 5'd1, 5'd0, 1'b0, 16'd2000, 5'd1, 5'd4);
      rdInt(5'd1, rv); chk("R10 date adjust", rv, e);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule